// File: doc/BRIEF.md
# I2C Own-Address Matcher (Dual Address, Maskable)

This block decides whether the address phase of an I2C transfer is meant for this device. A byte receiver in front of it hands over each received byte with a one-cycle strobe. It also raises a restart indication whenever the bus shows a STOP or a repeated START. The matcher compares the first byte against two programmed own addresses and answers with a one-cycle match pulse. With the pulse it reports which own address was hit and the read/write bit of the transfer.

The primary address can be 7 bits or 10 bits wide. In 10-bit mode it is recognised over two bytes: a header carrying the two top address bits, then the low address byte. The secondary address is always 7 bits and can be switched off. A 3-bit code narrows its comparison to fewer upper bits. One code value accepts any address outside the two reserved address groups. After deciding on an address phase, the matcher ignores bytes until the next restart indication. The configuration fields are plain inputs, held steady by the register block that owns them.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, match_pulse, match_sel and match_rw are all 0.
- R2: With the 10-bit mode bit at 0, a first byte whose bits 7:1 equal address-1 bits 7:1 gives match_pulse high for exactly the cycle after the strobe, with match_sel 0 and match_rw equal to byte bit 0. Address-1 bits 9:8 and 0 are not compared.
- R3: Address 2 never matches while its enable is 0. When enabled, a hit gives match_sel 1 and match_rw equal to byte bit 0.
- R4: Address-2 mask code k (0 to 6) compares byte bits 7:(k+1) with the corresponding bits of address 2. Lower bits are ignored.
- R5: Mask code 7 matches every first byte whose bits 7:1 are not of the form 0000xxx or 1111xxx. Those reserved forms never match through this code.
- R6: When address 1 and address 2 both match the same byte, match_sel is 0.
- R7: In 10-bit mode, a first byte 11110 followed by address-1 bits 9:8 and a R/W bit gives no pulse. A following byte equal to address-1 bits 7:0 pulses the cycle after its strobe, with match_sel 0 and match_rw taken from the first byte.
- R8: In 10-bit mode, a wrong header, a wrong second byte, or a 7-bit style compare of address 1 gives no pulse.
- R9: After the address decision, further bytes give no pulse until a restart indication. A restart resets the matcher and wins over a byte strobe in the same cycle, which is dropped.
- R10: match_pulse never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | One-cycle strobe: byte_data holds a received byte |
| byte_data | input | 8 | Received byte, bit 0 is the R/W bit of an address byte |
| frame_restart | input | 1 | STOP or repeated START seen; restarts address matching |
| cfg_addr1 | input | 10 | Own address 1 |
| cfg_addr1_10b | input | 1 | 1: address 1 is 10-bit, 0: 7-bit (bits 7:1 used) |
| cfg_addr2 | input | 7 | Own address 2 (7-bit) |
| cfg_addr2_en | input | 1 | Enables address 2 |
| cfg_addr2_mask | input | 3 | Address-2 compare range code |
| match_pulse | output | 1 | One-cycle pulse on an address match |
| match_sel | output | 1 | 0: address 1 matched, 1: address 2 matched |
| match_rw | output | 1 | R/W bit of the matched transfer |

## Verification
The matcher state is one of three phases plus a saved R/W bit. Any error in it shows at the ports on the very next strobe. A phase stuck after a decision silences every later address until restart. A skipped 10-bit header phase lets a lone low byte pulse. A stale R/W bit corrupts match_rw on the second 10-bit byte. Each stimulus group therefore starts with a restart and checks the pulse one cycle after each strobe. Each group also sends bytes after the decision, so a wrong phase becomes visible within two strobes.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int A7_W   = 7;
  localparam int A10_W  = 10;
  localparam int MASK_W = 3;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {ST_FIRST, ST_SECOND, ST_DONE} am_state_t;

  localparam logic [4:0] HDR10 = 5'b11110;
  localparam logic [MASK_W-1:0] CODE_ANY = '1;

  // 0000xxx and 1111xxx are kept for bus functions
  function automatic logic is_reserved(input logic [A7_W-1:0] a);
    return (a[A7_W-1 -: 4] == 4'b0000) || (a[A7_W-1 -: 4] == 4'b1111);
  endfunction

  // bits kept in the compare for a mask code below CODE_ANY
  function automatic logic [A7_W-1:0] keep_bits(input logic [MASK_W-1:0] code);
    return {A7_W{1'b1}} << code;
  endfunction

  function automatic logic addr2_hit(input logic [A7_W-1:0] a,
                                     input logic [A7_W-1:0] own,
                                     input logic [MASK_W-1:0] code);
    if (code == CODE_ANY) return !is_reserved(a);
    return ((a ^ own) & keep_bits(code)) == '0;
  endfunction
endpackage

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
  import i2c_am_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [A10_W-1:0]  cfg_addr1,
  input  logic              cfg_addr1_10b,
  input  logic [A7_W-1:0]   cfg_addr2,
  input  logic              cfg_addr2_en,
  input  logic [MASK_W-1:0] cfg_addr2_mask,
  output logic              hit_a1_7,
  output logic              hit_a1_hdr,
  output logic              hit_a1_lo,
  output logic              hit_a2
);
  always_comb begin
    hit_a1_7   = !cfg_addr1_10b && (byte_data[BYTE_W-1:1] == cfg_addr1[BYTE_W-1:1]);
    hit_a1_hdr = cfg_addr1_10b && (byte_data[7:3] == HDR10) &&
                 (byte_data[2:1] == cfg_addr1[9:8]);
    hit_a1_lo  = cfg_addr1_10b && (byte_data == cfg_addr1[BYTE_W-1:0]);
    hit_a2     = cfg_addr2_en &&
                 addr2_hit(byte_data[BYTE_W-1:1], cfg_addr2, cfg_addr2_mask);
  end
endmodule

// File: rtl/i2c_am_fsm.sv
module i2c_am_fsm
  import i2c_am_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic byte_valid,
  input  logic frame_restart,
  input  logic byte_rw,
  input  logic hit_a1_7,
  input  logic hit_a1_hdr,
  input  logic hit_a1_lo,
  input  logic hit_a2,
  output logic match_pulse,
  output logic match_sel,
  output logic match_rw
);
  am_state_t state;
  logic      hdr_rw;
  logic      take_byte;

  assign take_byte = byte_valid && !frame_restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_FIRST;
      hdr_rw      <= 1'b0;
      match_pulse <= 1'b0;
      match_sel   <= 1'b0;
      match_rw    <= 1'b0;
    end else begin
      match_pulse <= 1'b0;
      if (frame_restart) begin
        state <= ST_FIRST;
      end else if (take_byte) begin
        case (state)
          ST_FIRST: begin
            state <= ST_DONE;
            if (hit_a1_7) begin
              match_pulse <= 1'b1;
              match_sel   <= 1'b0;
              match_rw    <= byte_rw;
            end else if (hit_a1_hdr) begin
              hdr_rw <= byte_rw;
              state  <= ST_SECOND;
            end else if (hit_a2) begin
              match_pulse <= 1'b1;
              match_sel   <= 1'b1;
              match_rw    <= byte_rw;
            end
          end
          ST_SECOND: begin
            state <= ST_DONE;
            if (hit_a1_lo) begin
              match_pulse <= 1'b1;
              match_sel   <= 1'b0;
              match_rw    <= hdr_rw;
            end
          end
          default: state <= ST_DONE;
        endcase
      end
    end
  end

  AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(byte_valid)); // R2
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_restart) |-> !match_pulse); // R9
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> !match_pulse); // R10
  AST_SECOND_FROM_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SECOND) && $past(state != ST_SECOND) |-> $past(byte_valid && hit_a1_hdr)); // R7
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              frame_restart,
  input  logic [9:0]        cfg_addr1,
  input  logic              cfg_addr1_10b,
  input  logic [6:0]        cfg_addr2,
  input  logic              cfg_addr2_en,
  input  logic [2:0]        cfg_addr2_mask,
  output logic              match_pulse,
  output logic              match_sel,
  output logic              match_rw
);
  logic hit_a1_7, hit_a1_hdr, hit_a1_lo, hit_a2;

  i2c_am_cmp u_cmp (
    .byte_data      (byte_data),
    .cfg_addr1      (cfg_addr1),
    .cfg_addr1_10b  (cfg_addr1_10b),
    .cfg_addr2      (cfg_addr2),
    .cfg_addr2_en   (cfg_addr2_en),
    .cfg_addr2_mask (cfg_addr2_mask),
    .hit_a1_7       (hit_a1_7),
    .hit_a1_hdr     (hit_a1_hdr),
    .hit_a1_lo      (hit_a1_lo),
    .hit_a2         (hit_a2)
  );

  i2c_am_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .byte_valid    (byte_valid),
    .frame_restart (frame_restart),
    .byte_rw       (byte_data[0]),
    .hit_a1_7      (hit_a1_7),
    .hit_a1_hdr    (hit_a1_hdr),
    .hit_a1_lo     (hit_a1_lo),
    .hit_a2        (hit_a2),
    .match_pulse   (match_pulse),
    .match_sel     (match_sel),
    .match_rw      (match_rw)
  );

  AST_ADDR2_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse && match_sel |-> $past(cfg_addr2_en)); // R3
  AST_ANY_CODE_SKIPS_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse && match_sel && $past(cfg_addr2_mask == CODE_ANY)
    |-> !is_reserved($past(byte_data[7:1]))); // R5
  AST_ADDR1_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse && match_sel |-> !$past(hit_a1_7)); // R6
endmodule

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       frame_restart = 1'b0;
  logic [9:0] cfg_addr1 = '0;
  logic       cfg_addr1_10b = 1'b0;
  logic [6:0] cfg_addr2 = '0;
  logic       cfg_addr2_en = 1'b0;
  logic [2:0] cfg_addr2_mask = '0;
  logic       match_pulse, match_sel, match_rw;

  int errors = 0;
  int checks = 0;

  typedef struct {
    bit    hit;
    bit    sel;
    bit    rw;
    string req;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  i2c_addr_match i_i2c_addr_match (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .frame_restart(frame_restart), .cfg_addr1(cfg_addr1), .cfg_addr1_10b(cfg_addr1_10b),
    .cfg_addr2(cfg_addr2), .cfg_addr2_en(cfg_addr2_en), .cfg_addr2_mask(cfg_addr2_mask),
    .match_pulse(match_pulse), .match_sel(match_sel), .match_rw(match_rw)
  );

  // monitor: a byte taken at a posedge is answered by the following negedge
  bit seen = 1'b0;
  always @(posedge clk) seen <= rst_n && byte_valid && !frame_restart;

  always @(negedge clk) begin
    if (rst_n) begin
      if (seen) begin
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL scoreboard: byte with no expectation, pulse=%0b expected none", match_pulse);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          checks++;
          if (match_pulse !== e.hit ||
              (e.hit && (match_sel !== e.sel || match_rw !== e.rw))) begin
            errors++;
            $display("FAIL %s: pulse/sel/rw=%0b/%0b/%0b expected %0b/%0b/%0b",
                     e.req, match_pulse, match_sel, match_rw, e.hit, e.sel, e.rw);
          end
        end
      end else if (match_pulse) begin
        errors++;
        $display("FAIL R10: pulse=1 with no byte strobe one cycle earlier, expected 0");
      end
    end
  end

  task automatic send_byte(input logic [7:0] d, input bit hit, input bit sel,
                           input bit rw, input string req);
    exp_q.push_back('{hit, sel, rw, req});
    @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = d;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk);
    frame_restart = 1'b1;
    @(negedge clk);
    frame_restart = 1'b0;
  endtask

  task automatic restart_with_byte(input logic [7:0] d);
    @(negedge clk);
    frame_restart = 1'b1;
    byte_valid    = 1'b1;
    byte_data     = d;
    @(negedge clk);
    frame_restart = 1'b0;
    byte_valid    = 1'b0;
  endtask

  function automatic bit model_a2(input logic [6:0] a, input logic [6:0] own,
                                  input int code);
    if (code == 7) return !(a[6:3] == 4'h0 || a[6:3] == 4'hF);
    return (a >> code) == (own >> code);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({match_pulse, match_sel, match_rw} !== 3'b000) begin
      errors++;
      $display("FAIL R1: outputs=%b expected 000", {match_pulse, match_sel, match_rw});
    end
    rst_n = 1'b1;
    @(negedge clk);

    // 7-bit address 1 = 1010011, upper/lowest bits set to prove they are ignored
    cfg_addr1 = 10'h3A7;
    restart(); send_byte(8'hA6, 1, 0, 0, "R2 write");
    restart(); send_byte(8'hA7, 1, 0, 1, "R2 read");
    restart(); send_byte(8'hA4, 0, 0, 0, "R2 miss");
    send_byte(8'hA6, 0, 0, 0, "R9 ignored after decision");
    restart_with_byte(8'hA6);
    send_byte(8'hA7, 1, 0, 1, "R9 restart wins");
    send_byte(8'hA7, 0, 0, 0, "R10 second byte after hit");

    cfg_addr2 = 7'h30;
    restart(); send_byte(8'h60, 0, 0, 0, "R3 disabled");
    cfg_addr2_en = 1'b1;
    restart(); send_byte(8'h61, 1, 1, 1, "R3 enabled");
    cfg_addr2 = 7'h53;
    restart(); send_byte(8'hA6, 1, 0, 0, "R6 priority");

    // mask ranges, address 1 parked on a 10-bit value away from the probes
    cfg_addr1 = 10'h3FF; cfg_addr1_10b = 1'b1; cfg_addr2 = 7'h55;
    for (int code = 0; code < 7; code++) begin
      cfg_addr2_mask = 3'(code);
      for (int j = 0; j < 7; j++) begin
        logic [6:0] probe;
        probe = cfg_addr2 ^ 7'(1 << j);
        restart();
        send_byte({probe, 1'b0}, model_a2(probe, cfg_addr2, code), 1, 0, "R4 mask range");
      end
    end
    cfg_addr2_mask = 3'd7;
    for (int a = 0; a < 128; a++) begin
      restart();
      send_byte({7'(a), 1'b1}, model_a2(7'(a), cfg_addr2, 7), 1, 1, "R5 any non-reserved");
    end

    // 10-bit address 1 = 10'h2B7
    cfg_addr2_en = 1'b0; cfg_addr1 = 10'h2B7;
    restart(); send_byte(8'hF4, 0, 0, 0, "R7 header no pulse");
    send_byte(8'hB7, 1, 0, 0, "R7 low byte write");
    restart(); send_byte(8'hF5, 0, 0, 0, "R7 header read");
    send_byte(8'hB7, 1, 0, 1, "R7 low byte read");
    restart(); send_byte(8'hF4, 0, 0, 0, "R8 header");
    send_byte(8'hB6, 0, 0, 0, "R8 wrong low byte");
    restart(); send_byte(8'hF2, 0, 0, 0, "R8 wrong header");
    send_byte(8'hB7, 0, 0, 0, "R8 low byte after bad header");
    restart(); send_byte(8'hB6, 0, 0, 0, "R8 no 7-bit compare");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d expectations left, expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule